// File: doc/BRIEF.md
# NAND Flash Bus Cycle Timer

This block produces the strobe timing for a single 8-bit NAND flash device and sits behind a simple register-style host port. The host picks one of four ports with a two-bit select. A write to the command port or the address port starts a flash bus cycle with the command latch or address latch enable raised. A write or read on the data port moves one byte over the flash data bus. Port 0 holds the timing and control word and returns the device ready status when read.

Every flash bus cycle has three phases. The setup phase comes first. The strobe phase follows, and write enable or read enable is low only during that phase. The hold phase comes last. Each phase length comes from its own configuration field, which stores the cycle count minus one. While a cycle runs the host sees `hst_rdy` low, and it gets no new access accepted until the hold phase has finished. The active-low chip enable follows one configuration bit and nothing else. The ready/busy pin of the device goes through two flip-flops before it reaches the status bit.

Top module: `nand_strobe_timer`

## Requirements
- R1: After reset, `nf_ce_n`=1, `nf_cle`=0, `nf_ale`=0, `nf_we_n`=1, `nf_re_n`=1, `nf_dq_oe`=0 and `hst_rdy`=1. A read of port 0 returns strobe field 7, hold field 7 and setup field at its maximum, with enable 0 and deselect 1.
- R2: Port 0 bits [2:0] set the strobe phase and bits [5:3] set the hold phase. A field value n gives n+1 clock cycles, for any n from 0 to 7.
- R3: Port 0 bits [8:6] set the setup phase, also as n+1 cycles. With the default narrow setting only bits [7:6] are stored, so the maximum is 4 cycles, and bit 8 is ignored and reads 0. With `WIDE_SETUP`=1 all three bits are stored, giving up to 8 cycles.
- R4: A write to port 1 (command) starts a cycle. `nf_cle` is high in all three phases, `nf_ale` stays low, `nf_we_n` is low only in the strobe phase, and `nf_dq_out` carries the low byte of `hst_wdata` with `nf_dq_oe` high.
- R5: A write to port 2 (address) starts a cycle of the same shape as R4, with `nf_ale` in place of `nf_cle`.
- R6: A write to port 3 (data) starts a cycle with neither latch enable raised, `nf_we_n` low only in the strobe phase, and the low data byte driven.
- R7: A read of port 3 holds `nf_re_n` low only in the strobe phase and never lowers `nf_we_n`. The byte on `nf_dq_in` in the last strobe cycle is captured. It is returned in `hst_rdata` with a one-cycle `hst_rvalid` in the first cycle that `hst_rdy` is high again.
- R8: `hst_rdy` is low from the cycle after a bus cycle is accepted until its hold phase ends. A request held during that time, including a port 0 write, is accepted only afterwards and does not change the cycle already running.
- R9: While port 0 bit 9 (enable) is 0, port accesses start no bus cycle and `hst_rdy` stays high. A data read then returns `hst_rvalid` in the next cycle with data 0.
- R10: Port 0 bit 10 drives `nf_ce_n` directly (1 = deselected, 0 = selected). Bus cycles never change it.
- R11: A port 0 read returns `hst_rvalid` in the next cycle, and bit 11 is `nf_rb` (1 = ready, 0 = busy) as seen through a two-flop synchroniser. A change of `nf_rb` is not visible to a read accepted at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hst_req | input | 1 | Host access request, taken when `hst_rdy` is high |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_sel | input | 2 | Port: 0 config/status, 1 command, 2 address, 3 data |
| hst_wdata | input | HOST_W | Write data |
| hst_rdy | output | 1 | High when an access can be accepted |
| hst_rvalid | output | 1 | Read data valid, one cycle |
| hst_rdata | output | HOST_W | Read data |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write enable, active low |
| nf_re_n | output | 1 | Read enable, active low |
| nf_dq_out | output | BUS_W | Flash data bus, outgoing |
| nf_dq_oe | output | 1 | Drive enable for `nf_dq_out` |
| nf_dq_in | input | BUS_W | Flash data bus, incoming |
| nf_rb | input | 1 | Device ready/busy pin, 1 = ready |

## Verification
Two events can fall in the same cycle: the end of a running bus cycle's hold phase and a host write to the timing word. The bench raises a port 0 write with new timing one cycle after a command cycle starts and keeps it raised. It then checks two things: that the running cycle keeps its old phase lengths and total busy time, and that the new word appears on read-back only once `hst_rdy` has returned. A second overlap is a change of `nf_rb` next to a status read. The bench issues the read right after the pin moves and expects the old value, then expects the new value a few cycles later.

// File: rtl/nand_tmr_pkg.sv
package nand_tmr_pkg;
   localparam int CNT_W        = 3;
   localparam int F_STROBE_LSB = 0;
   localparam int F_HOLD_LSB   = 3;
   localparam int F_SETUP_LSB  = 6;
   localparam int F_EN_BIT     = 9;
   localparam int F_CEOFF_BIT  = 10;
   localparam int CFG_W        = 11;
   localparam int F_RDY_BIT    = 11;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_STROBE = 2'd2,
      PH_HOLD   = 2'd3
   } phase_e;

   typedef enum logic [1:0] {
      PORT_CFG  = 2'd0,
      PORT_CMD  = 2'd1,
      PORT_ADDR = 2'd2,
      PORT_DATA = 2'd3
   } port_e;

   typedef enum logic [1:0] {
      OP_CMD   = 2'd0,
      OP_ADDR  = 2'd1,
      OP_WDATA = 2'd2,
      OP_RDATA = 2'd3
   } op_e;
endpackage

// File: rtl/nand_tmr_sync.sv
module nand_tmr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] sr_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("nand_tmr_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= {sr_q[STAGES-2:0], din};
   end

   assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/nand_tmr_cfg.sv
module nand_tmr_cfg
   import nand_tmr_pkg::*;
#(
   parameter int SETUP_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wdata,
   output logic [CNT_W-1:0] setup_len,
   output logic [CNT_W-1:0] strobe_len,
   output logic [CNT_W-1:0] hold_len,
   output logic             enable,
   output logic             ce_off,
   output logic [CFG_W-1:0] cfg_word
);
   logic [SETUP_W-1:0] setup_q;
   logic [CNT_W-1:0]   strobe_q;
   logic [CNT_W-1:0]   hold_q;
   logic               en_q;
   logic               ceoff_q;

   generate
      if (SETUP_W < 1 || SETUP_W > CNT_W) begin : g_bad_setup
         $error("nand_tmr_cfg: SETUP_W out of range");
      end
      if (SETUP_W == CNT_W) begin : g_wide
         assign setup_len = setup_q;
      end else begin : g_narrow
         logic unused_setup_hi;
         assign setup_len = {{(CNT_W-SETUP_W){1'b0}}, setup_q};
         assign unused_setup_hi = ^wdata[F_SETUP_LSB+CNT_W-1 : F_SETUP_LSB+SETUP_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         setup_q  <= '1;
         strobe_q <= '1;
         hold_q   <= '1;
         en_q     <= 1'b0;
         ceoff_q  <= 1'b1;
      end else if (wr_en) begin
         setup_q  <= wdata[F_SETUP_LSB +: SETUP_W];
         strobe_q <= wdata[F_STROBE_LSB +: CNT_W];
         hold_q   <= wdata[F_HOLD_LSB +: CNT_W];
         en_q     <= wdata[F_EN_BIT];
         ceoff_q  <= wdata[F_CEOFF_BIT];
      end
   end

   assign strobe_len = strobe_q;
   assign hold_len   = hold_q;
   assign enable     = en_q;
   assign ce_off     = ceoff_q;
   assign cfg_word   = {ceoff_q, en_q, setup_len, hold_q, strobe_q};
endmodule

// File: rtl/nand_tmr_seq.sv
module nand_tmr_seq
   import nand_tmr_pkg::*;
#(
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  op_e              op,
   input  logic [BUS_W-1:0] wbyte,
   input  logic [CNT_W-1:0] setup_len,
   input  logic [CNT_W-1:0] strobe_len,
   input  logic [CNT_W-1:0] hold_len,
   input  logic [BUS_W-1:0] dq_in,
   output logic             idle,
   output logic             cle,
   output logic             ale,
   output logic             we_n,
   output logic             re_n,
   output logic [BUS_W-1:0] dq_out,
   output logic             dq_oe,
   output logic             rd_done,
   output logic [BUS_W-1:0] rd_byte
);
   phase_e           phase_q;
   logic [CNT_W-1:0] cnt_q;
   op_e              op_q;
   logic [BUS_W-1:0] wbyte_q;
   logic [BUS_W-1:0] rbyte_q;
   logic             last;
   logic             is_read;

   assign last    = (cnt_q == '0);
   assign is_read = (op_q == OP_RDATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         op_q    <= OP_CMD;
         wbyte_q <= '0;
         rbyte_q <= '0;
      end else begin
         case (phase_q)
            PH_IDLE: if (start) begin
               phase_q <= PH_SETUP;
               cnt_q   <= setup_len;
               op_q    <= op;
               wbyte_q <= wbyte;
            end
            PH_SETUP: if (last) begin
               phase_q <= PH_STROBE;
               cnt_q   <= strobe_len;
            end else cnt_q <= cnt_q - 1'b1;
            PH_STROBE: if (last) begin
               phase_q <= PH_HOLD;
               cnt_q   <= hold_len;
               if (is_read) rbyte_q <= dq_in;
            end else cnt_q <= cnt_q - 1'b1;
            default: if (last) phase_q <= PH_IDLE;
                     else      cnt_q   <= cnt_q - 1'b1;
         endcase
      end
   end

   assign idle    = (phase_q == PH_IDLE);
   assign cle     = !idle && (op_q == OP_CMD);
   assign ale     = !idle && (op_q == OP_ADDR);
   assign we_n    = !((phase_q == PH_STROBE) && !is_read);
   assign re_n    = !((phase_q == PH_STROBE) && is_read);
   assign dq_oe   = !idle && !is_read;
   assign dq_out  = wbyte_q;
   assign rd_done = (phase_q == PH_HOLD) && last && is_read;
   assign rd_byte = rbyte_q;
endmodule

// File: rtl/nand_strobe_timer.sv
module nand_strobe_timer
   import nand_tmr_pkg::*;
#(
   parameter int HOST_W     = 32,
   parameter int BUS_W      = 8,
   parameter bit WIDE_SETUP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_req,
   input  logic              hst_we,
   input  logic [1:0]        hst_sel,
   input  logic [HOST_W-1:0] hst_wdata,
   output logic              hst_rdy,
   output logic              hst_rvalid,
   output logic [HOST_W-1:0] hst_rdata,
   output logic              nf_ce_n,
   output logic              nf_cle,
   output logic              nf_ale,
   output logic              nf_we_n,
   output logic              nf_re_n,
   output logic [BUS_W-1:0]  nf_dq_out,
   output logic              nf_dq_oe,
   input  logic [BUS_W-1:0]  nf_dq_in,
   input  logic              nf_rb
);
   localparam int SETUP_W = WIDE_SETUP ? CNT_W : CNT_W - 1;

   generate
      if (HOST_W < F_RDY_BIT + 1) begin : g_bad_host
         $error("nand_strobe_timer: HOST_W too small for the control word");
      end
      if (BUS_W < 1 || BUS_W > CFG_W) begin : g_bad_bus
         $error("nand_strobe_timer: BUS_W out of range");
      end
   endgenerate

   logic             idle, accept, cfg_wr, cfg_rd, start, imm_zero;
   logic             enable, ce_off, rb_sync, rd_done;
   logic [CNT_W-1:0] setup_len, strobe_len, hold_len;
   logic [CFG_W-1:0] cfg_word;
   logic [BUS_W-1:0] rd_byte;
   op_e              op;
   logic             unused_wdata_hi;

   assign unused_wdata_hi = ^hst_wdata[HOST_W-1:CFG_W];

   assign hst_rdy  = idle;
   assign accept   = hst_req && idle;
   assign cfg_wr   = accept && hst_we && (hst_sel == PORT_CFG);
   assign cfg_rd   = accept && !hst_we && (hst_sel == PORT_CFG);
   assign start    = accept && enable && (hst_sel != PORT_CFG)
                     && (hst_we || hst_sel == PORT_DATA);
   assign imm_zero = accept && !hst_we && (hst_sel != PORT_CFG) && !start;

   always_comb begin
      case (hst_sel)
         PORT_CMD:  op = OP_CMD;
         PORT_ADDR: op = OP_ADDR;
         default:   op = hst_we ? OP_WDATA : OP_RDATA;
      endcase
   end

   nand_tmr_cfg #(.SETUP_W(SETUP_W)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cfg_wr),
      .wdata      (hst_wdata[CFG_W-1:0]),
      .setup_len  (setup_len),
      .strobe_len (strobe_len),
      .hold_len   (hold_len),
      .enable     (enable),
      .ce_off     (ce_off),
      .cfg_word   (cfg_word)
   );

   nand_tmr_sync #(.STAGES(2)) u_rb_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (nf_rb),
      .dout  (rb_sync)
   );

   nand_tmr_seq #(.BUS_W(BUS_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .op         (op),
      .wbyte      (hst_wdata[BUS_W-1:0]),
      .setup_len  (setup_len),
      .strobe_len (strobe_len),
      .hold_len   (hold_len),
      .dq_in      (nf_dq_in),
      .idle       (idle),
      .cle        (nf_cle),
      .ale        (nf_ale),
      .we_n       (nf_we_n),
      .re_n       (nf_re_n),
      .dq_out     (nf_dq_out),
      .dq_oe      (nf_dq_oe),
      .rd_done    (rd_done),
      .rd_byte    (rd_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hst_rvalid <= 1'b0;
         hst_rdata  <= '0;
      end else begin
         hst_rvalid <= cfg_rd || imm_zero || rd_done;
         if (cfg_rd)
            hst_rdata <= HOST_W'({rb_sync, cfg_word});
         else if (imm_zero)
            hst_rdata <= '0;
         else if (rd_done)
            hst_rdata <= HOST_W'(rd_byte);
      end
   end

   assign nf_ce_n = ce_off;
endmodule

// File: rtl/nand_tmr_chk.sv
module nand_tmr_chk (
   input logic clk,
   input logic rst_n,
   input logic hst_rdy,
   input logic hst_rvalid,
   input logic nf_cle,
   input logic nf_ale,
   input logic nf_we_n,
   input logic nf_re_n,
   input logic nf_ce_n,
   input logic enable,
   input logic cfg_wr
);
   logic       strobe;
   logic [3:0] run_q;

   assign strobe = !nf_we_n || !nf_re_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          run_q <= '0;
      else if (!strobe)    run_q <= '0;
      else if (run_q != 4'hF) run_q <= run_q + 1'b1;
   end

   p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nf_we_n && !nf_re_n));
   p_latch_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(nf_cle && nf_ale));
   p_busy_handshake_r8: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> !hst_rdy);
   p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (nf_we_n && nf_re_n && !nf_cle && !nf_ale));
   p_ce_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_wr) |-> $stable(nf_ce_n));
   p_strobe_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> (run_q < 4'd8));
   p_rvalid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hst_rvalid |-> hst_rdy);
endmodule

bind nand_strobe_timer nand_tmr_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hst_rdy    (hst_rdy),
   .hst_rvalid (hst_rvalid),
   .nf_cle     (nf_cle),
   .nf_ale     (nf_ale),
   .nf_we_n    (nf_we_n),
   .nf_re_n    (nf_re_n),
   .nf_ce_n    (nf_ce_n),
   .enable     (enable),
   .cfg_wr     (cfg_wr)
);

// File: tb/tb_nand_strobe_timer.sv
module tb_nand_strobe_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hst_req = 1'b0;
   logic        hst_we = 1'b0;
   logic [1:0]  hst_sel = 2'd0;
   logic [31:0] hst_wdata = '0;
   logic        hst_rdy, hst_rvalid;
   logic [31:0] hst_rdata;
   logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
   logic [7:0]  nf_dq_out;
   logic [7:0]  nf_dq_in = 8'h00;
   logic        nf_rb = 1'b1;

   localparam logic [7:0] RD_A = 8'h3C;
   localparam logic [7:0] RD_B = 8'hC3;

   int  nchk = 0;
   int  nfail = 0;
   bit  done = 0;
   logic exp_ce_n = 1'b1;

   always #5 clk = ~clk;

   nand_strobe_timer dut (
      .clk(clk), .rst_n(rst_n), .hst_req(hst_req), .hst_we(hst_we),
      .hst_sel(hst_sel), .hst_wdata(hst_wdata), .hst_rdy(hst_rdy),
      .hst_rvalid(hst_rvalid), .hst_rdata(hst_rdata), .nf_ce_n(nf_ce_n),
      .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
      .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in),
      .nf_rb(nf_rb)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(int s, int w, int h, bit en, bit ce);
      return 32'(w) | (32'(h) << 3) | (32'(s) << 6) | (32'(en) << 9) | (32'(ce) << 10);
   endfunction

   task automatic cfg_write(input logic [31:0] v);
      @(negedge clk);
      hst_req = 1; hst_sel = 2'd0; hst_we = 1; hst_wdata = v;
      @(posedge clk);
      @(negedge clk);
      hst_req = 0;
      exp_ce_n = v[10];
   endtask

   task automatic cfg_read(output logic rv, output logic [31:0] rd);
      @(negedge clk);
      hst_req = 1; hst_sel = 2'd0; hst_we = 0;
      @(posedge clk);
      @(negedge clk);
      hst_req = 0;
      rv = hst_rvalid; rd = hst_rdata;
   endtask

   task automatic run_op(input logic [1:0] sel, input logic we, input logic [31:0] wd,
                         input int w_exp, output int ns, output int nst, output int nh,
                         output bit shape_ok, output logic rv, output logic [31:0] rd);
      int k = 0;
      bit seen = 0;
      logic strobe;
      ns = 0; nst = 0; nh = 0; shape_ok = 1;
      @(negedge clk);
      hst_req = 1; hst_sel = sel; hst_we = we; hst_wdata = wd; nf_dq_in = RD_A;
      @(posedge clk);
      @(negedge clk);
      hst_req = 0;
      while (!hst_rdy) begin
         strobe = !nf_we_n || !nf_re_n;
         if (strobe) begin nst++; seen = 1; end
         else if (seen) nh++;
         else ns++;
         if (!nf_re_n) begin
            k++;
            nf_dq_in = (k == w_exp + 1) ? RD_B : RD_A;
         end
         if (nf_cle !== (sel == 2'd1)) shape_ok = 0;
         if (nf_ale !== (sel == 2'd2)) shape_ok = 0;
         if (nf_dq_oe !== we) shape_ok = 0;
         if ((!nf_we_n) !== (strobe && we)) shape_ok = 0;
         if ((!nf_re_n) !== (strobe && !we)) shape_ok = 0;
         if (we && nf_dq_out !== wd[7:0]) shape_ok = 0;
         if (nf_ce_n !== exp_ce_n) shape_ok = 0;
         @(negedge clk);
      end
      rv = hst_rvalid; rd = hst_rdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog run did not complete");
      finish_run();
   end

   initial begin
      int ns, nst, nh, nb, nwe;
      bit ok, quiet;
      logic rv;
      logic [31:0] rd;

      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1;
      repeat (3) @(negedge clk);

      // R1 reset state
      chk(nf_ce_n === 1 && nf_cle === 0 && nf_ale === 0 && nf_we_n === 1 &&
          nf_re_n === 1 && nf_dq_oe === 0 && hst_rdy === 1, "R1", "pins after reset",
          {nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe, hst_rdy}, 7'b1001101);
      cfg_read(rv, rd);
      chk(rv === 1 && (rd & 32'h7FF) === mk(3, 7, 7, 0, 1), "R1", "reset config",
          rd, mk(3, 7, 7, 0, 1));

      // R2 R3 R4 full sweep of phase lengths with command writes
      for (int s = 0; s < 4; s++)
         for (int w = 0; w < 8; w++)
            for (int h = 0; h < 8; h++) begin
               cfg_write(mk(s, w, h, 1, 0));
               run_op(2'd1, 1, 32'h0000_01A5, w, ns, nst, nh, ok, rv, rd);
               chk((ns == s + 1) && (nst == w + 1) && (nh == h + 1), "R2_R3",
                   "setup/strobe/hold cycles", (ns << 8) | (nst << 4) | nh,
                   ((s + 1) << 8) | ((w + 1) << 4) | (h + 1));
               chk(ok, "R4", "command cycle shape", 0, 1);
            end

      // R3 narrow setup field drops bit 8
      cfg_write(mk(7, 0, 0, 1, 0));
      cfg_read(rv, rd);
      chk(rd === (mk(3, 0, 0, 1, 0) | 32'h800), "R3", "setup bit 8 ignored",
          rd, mk(3, 0, 0, 1, 0) | 32'h800);
      run_op(2'd1, 1, 32'h11, 0, ns, nst, nh, ok, rv, rd);
      chk(ns == 4, "R3", "max setup is 4 cycles", ns, 4);

      // R5 address cycles
      for (int w = 0; w < 8; w += 3) begin
         cfg_write(mk(2, w, 1, 1, 0));
         run_op(2'd2, 1, 32'hABCD_EF77, w, ns, nst, nh, ok, rv, rd);
         chk(ok && ns == 3 && nst == w + 1 && nh == 2, "R5", "address cycle",
             (ns << 8) | (nst << 4) | nh, (3 << 8) | ((w + 1) << 4) | 2);
      end

      // R6 data writes
      for (int h = 0; h < 8; h += 7) begin
         cfg_write(mk(0, 2, h, 1, 0));
         run_op(2'd3, 1, 32'hFFFF_FF5A, 2, ns, nst, nh, ok, rv, rd);
         chk(ok && ns == 1 && nst == 3 && nh == h + 1, "R6", "data write cycle",
             (ns << 8) | (nst << 4) | nh, (1 << 8) | (3 << 4) | (h + 1));
      end

      // R7 data reads, byte from last strobe cycle
      for (int w = 0; w < 8; w++) begin
         cfg_write(mk(1, w, 2, 1, 0));
         run_op(2'd3, 0, 32'h0, w, ns, nst, nh, ok, rv, rd);
         chk(ok && nst == w + 1 && ns == 2 && nh == 3, "R7", "read cycle shape",
             (ns << 8) | (nst << 4) | nh, (2 << 8) | ((w + 1) << 4) | 3);
         chk(rv === 1 && rd === 32'(RD_B), "R7", "read byte", rd, 32'(RD_B));
      end

      // R8 config write held while a cycle is running
      cfg_write(mk(1, 2, 1, 1, 0));
      @(negedge clk);
      hst_req = 1; hst_sel = 2'd1; hst_we = 1; hst_wdata = 32'h42;
      @(posedge clk);
      @(negedge clk);
      hst_sel = 2'd0; hst_wdata = mk(0, 0, 0, 1, 0);
      nb = 0; nwe = 0;
      while (!hst_rdy) begin
         nb++;
         if (!nf_we_n) nwe++;
         @(negedge clk);
      end
      @(posedge clk);
      @(negedge clk);
      hst_req = 0;
      chk(nb == 7 && nwe == 3, "R8", "running cycle unchanged", (nb << 4) | nwe,
          (7 << 4) | 3);
      cfg_read(rv, rd);
      chk((rd & 32'h7FF) === mk(0, 0, 0, 1, 0), "R8", "held write lands after",
          rd & 32'h7FF, mk(0, 0, 0, 1, 0));

      // R9 disabled: no bus cycles
      cfg_write(mk(1, 1, 1, 0, 0));
      @(negedge clk);
      hst_req = 1; hst_sel = 2'd1; hst_we = 1; hst_wdata = 32'h99;
      @(posedge clk);
      @(negedge clk);
      hst_req = 0;
      quiet = 1;
      for (int i = 0; i < 10; i++) begin
         if (!hst_rdy || nf_cle || !nf_we_n || nf_dq_oe) quiet = 0;
         @(negedge clk);
      end
      chk(quiet, "R9", "no cycle while disabled", 0, 1);
      @(negedge clk);
      hst_req = 1; hst_sel = 2'd3; hst_we = 0;
      @(posedge clk);
      @(negedge clk);
      hst_req = 0;
      chk(hst_rvalid === 1 && hst_rdata === 0 && hst_rdy === 1 && nf_re_n === 1,
          "R9", "disabled data read", hst_rdata, 0);

      // R10 chip enable
      cfg_write(mk(0, 0, 0, 1, 1));
      chk(nf_ce_n === 1, "R10", "deselect", nf_ce_n, 1);
      run_op(2'd2, 1, 32'h5, 0, ns, nst, nh, ok, rv, rd);
      chk(ok && nf_ce_n === 1, "R10", "ce kept high across cycle", nf_ce_n, 1);
      cfg_write(mk(0, 0, 0, 1, 0));
      chk(nf_ce_n === 0, "R10", "select", nf_ce_n, 0);

      // R11 ready status through synchroniser
      @(negedge clk);
      nf_rb = 0;
      cfg_read(rv, rd);
      chk(rv === 1 && rd[11] === 1, "R11", "status not yet changed", rd[11], 1);
      repeat (3) @(negedge clk);
      cfg_read(rv, rd);
      chk(rv === 1 && rd[11] === 0, "R11", "status busy", rd[11], 0);
      nf_rb = 1;
      repeat (4) @(negedge clk);
      cfg_read(rv, rd);
      chk(rv === 1 && rd[11] === 1, "R11", "status ready", rd[11], 1);

      finish_run();
   end
endmodule